// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block computes the memory address of a load or store from a 3-bit mode code, an absolute address field, a 12-bit signed immediate, a base register value, an index register value and the program counter. A single datapath covers seven ways of forming the address. The block is meant to sit between instruction decode and the memory pipeline.

For the auto-update mode the block also returns a new value for the base register, with an enable, so that the register file can be written in the same step. The step is the access size. A direction bit chooses add or subtract. A pre/post bit chooses whether the address uses the new or the old base.

Results are registered. A request is taken when `in_valid` and `in_ready` are both high. The result appears on the next cycle with `out_valid` and stays there until `out_ready` takes it.

Top module: `ldst_addr_gen`

## Requirements
- R1: Mode code 0 (absolute): `out_addr` equals `in_field`.
- R2: Mode code 1 (register indirect): `out_addr` equals `in_base`.
- R3: Mode code 2 (displacement): `out_addr` is `in_base` plus `in_offset`. The offset is taken as two's complement with bit 11 as its sign and is sign-extended to 32 bits. All sums wrap modulo 2^32.
- R4: Mode code 3 (indexed): `out_addr` is `in_base` plus `in_index`, wrapping.
- R5: Mode code 4 (scaled): `out_addr` is `in_base` + `in_index` × 2^`in_scale` + sign-extended `in_offset`, wrapping. `in_scale` values 0, 1, 2 and 3 give factors 1, 2, 4 and 8.
- R6: Mode code 5 (PC-relative): `out_addr` is `in_pc` plus sign-extended `in_offset`, wrapping.
- R7: Mode code 6 (auto-update): the step is 2^`in_size` bytes. `out_wb_data` is `in_base` + step when `in_dec`=0, and `in_base` − step when `in_dec`=1, wrapping. `out_wb_en` is 1. `out_addr` equals `out_wb_data` when `in_pre`=1 and equals `in_base` when `in_pre`=0.
- R8: Mode code 7 is illegal. It gives `out_err`=1, `out_wb_en`=0 and `out_addr`=0. Every legal mode gives `out_err`=0. Modes 0 to 5 give `out_wb_en`=0 and `out_wb_data`=0.
- R9: `in_ready` equals NOT `out_valid` OR `out_ready`. A request accepted at one rising edge shows up with `out_valid`=1 after that edge. `out_valid` drops after an edge where it was high with `out_ready` high and no new request was accepted.
- R10: While `out_valid`=1 and `out_ready`=0, every output holds its value across the edge.
- R11: After reset, `out_valid`, `out_wb_en` and `out_err` are 0, and `out_addr` and `out_wb_data` are 0. Whenever `out_valid`=0, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 3 | Address mode code (0 to 6 legal, 7 illegal) |
| in_field | input | 32 | Absolute address field |
| in_offset | input | 12 | Signed immediate displacement |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_pc | input | 32 | Program counter |
| in_scale | input | 2 | Index scale, as a power of two |
| in_size | input | 2 | Access size, as a power of two, in bytes |
| in_dec | input | 1 | 1 selects decrement in auto-update |
| in_pre | input | 1 | 1 selects the updated value as the address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective address |
| out_wb_en | output | 1 | Base register write-back enable |
| out_wb_data | output | 32 | Base register write-back value |
| out_err | output | 1 | Illegal mode flag |

## Verification
The bench aims at the sign bit of the immediate. The extreme offsets 0x800 and 0x7FF are applied against bases near zero and near the top of the space. A design that zero-extends the offset, or loses the carry, would give an address off by 4096 or fail to wrap. Auto-update is driven in all four direction and pre/post combinations, including a decrement from zero. Swapping pre and post, or taking the step from the scale field instead of the size field, shows up as a wrong address or a wrong write-back value. Mode 7 is checked for the error flag and for a write-back that stays off. Random back-pressure on `out_ready` tests that a stalled result is neither lost nor overwritten.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
  typedef enum logic [2:0] {
    AM_ABS  = 3'd0,
    AM_IND  = 3'd1,
    AM_DISP = 3'd2,
    AM_IDX  = 3'd3,
    AM_SCL  = 3'd4,
    AM_PCR  = 3'd5,
    AM_AUTO = 3'd6,
    AM_BAD  = 3'd7
  } amode_e;
endpackage

// File: rtl/agu_opnd.sv
module agu_opnd #(
  parameter int AW = 32,
  parameter int OW = 12,
  parameter int SW = 2
) (
  input  logic [OW-1:0] offset,
  input  logic [AW-1:0] index,
  input  logic [SW-1:0] scale,
  output logic [AW-1:0] off_ext,
  output logic [AW-1:0] idx_scaled
);
  function automatic logic [AW-1:0] sext_imm(input logic [OW-1:0] v);
    return {{(AW-OW){v[OW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] shift_idx(input logic [AW-1:0] v, input logic [SW-1:0] s);
    return v << s;
  endfunction

  assign off_ext    = sext_imm(offset);
  assign idx_scaled = shift_idx(index, scale);
endmodule

// File: rtl/agu_addr_core.sv
module agu_addr_core
  import ldst_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int ZW = 2
) (
  input  amode_e        mode,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] off_ext,
  input  logic [AW-1:0] idx_scaled,
  input  logic [AW-1:0] index,
  input  logic [ZW-1:0] size,
  input  logic          dec,
  input  logic          pre,
  output logic [AW-1:0] step,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          err
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] b,
                                         input logic [AW-1:0] s,
                                         input logic d);
    return d ? (b - s) : (b + s);
  endfunction

  logic [AW-1:0] upd;
  assign step = ONE << size;
  assign upd  = bump(base, step, dec);

  always_comb begin
    addr    = '0;
    wb_en   = 1'b0;
    wb_data = '0;
    err     = 1'b0;
    unique case (mode)
      AM_ABS:  addr = field;
      AM_IND:  addr = base;
      AM_DISP: addr = base + off_ext;
      AM_IDX:  addr = base + index;
      AM_SCL:  addr = base + idx_scaled + off_ext;
      AM_PCR:  addr = pc + off_ext;
      AM_AUTO: begin
        addr    = pre ? upd : base;
        wb_en   = 1'b1;
        wb_data = upd;
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic load;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      q         <= '0;
    end
  end
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 12,
  parameter int SW = 2,
  parameter int ZW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_mode,
  input  logic [AW-1:0] in_field,
  input  logic [OW-1:0] in_offset,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] in_index,
  input  logic [AW-1:0] in_pc,
  input  logic [SW-1:0] in_scale,
  input  logic [ZW-1:0] in_size,
  input  logic          in_dec,
  input  logic          in_pre,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_wb_en,
  output logic [AW-1:0] out_wb_data,
  output logic          out_err
);
  localparam int PW = 2 * AW + 2;

  logic [AW-1:0] off_ext, idx_scaled, step, c_addr, c_wb_data;
  logic          c_wb_en, c_err;
  logic          acc_fire;
  logic [PW-1:0] pay_d, pay_q;

  agu_opnd #(.AW(AW), .OW(OW), .SW(SW)) u_opnd (
    .offset(in_offset), .index(in_index), .scale(in_scale),
    .off_ext(off_ext), .idx_scaled(idx_scaled)
  );

  agu_addr_core #(.AW(AW), .ZW(ZW)) u_core (
    .mode(amode_e'(in_mode)), .field(in_field), .base(in_base), .pc(in_pc),
    .off_ext(off_ext), .idx_scaled(idx_scaled), .index(in_index),
    .size(in_size), .dec(in_dec), .pre(in_pre), .step(step),
    .addr(c_addr), .wb_en(c_wb_en), .wb_data(c_wb_data), .err(c_err)
  );

  assign pay_d    = {c_addr, c_wb_data, c_wb_en, c_err};
  assign acc_fire = in_valid && in_ready;

  agu_out_stage #(.W(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d(pay_d), .out_valid(out_valid), .out_ready(out_ready), .q(pay_q)
  );

  assign {out_addr, out_wb_data, out_wb_en, out_err} = pay_q;
endmodule

// File: rtl/ldst_addr_gen_chk.sv
module ldst_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_fire,
  input logic          in_ready,
  input logic [2:0]    in_mode,
  input logic [AW-1:0] in_base,
  input logic          in_pre,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_wb_en,
  input logic [AW-1:0] out_wb_data,
  input logic          out_err
);
  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> out_valid);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_wb_data) && $stable(out_wb_en) && $stable(out_err)));

  a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_mode == 3'd7) |=> (out_err && !out_wb_en));

  a_r8_no_wb_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_mode != 3'd6) |=> !out_wb_en);

  a_r7_pre_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_mode == 3'd6 && in_pre) |=> (out_wb_en && out_addr == out_wb_data));

  a_r7_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && in_mode == 3'd6 && !in_pre) |=> (out_wb_en && out_addr == $past(in_base)));

  a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wb_en && !out_err && out_addr == '0 && out_wb_data == '0));

  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_wb_en, out_err}) <= 1);
endmodule

bind ldst_addr_gen ldst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .in_ready(in_ready),
  .in_mode(in_mode), .in_base(in_base), .in_pre(in_pre),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_wb_en(out_wb_en), .out_wb_data(out_wb_data), .out_err(out_err)
);

// File: tb/ldst_addr_gen_bench.sv
`timescale 1ns/1ps
module ldst_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  in_mode = '0;
  logic [31:0] in_field = '0, in_base = '0, in_index = '0, in_pc = '0;
  logic [11:0] in_offset = '0;
  logic [1:0]  in_scale = '0, in_size = '0;
  logic        in_dec = 1'b0, in_pre = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_addr, out_wb_data;
  logic        out_wb_en, out_err;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [31:0] e_addr, e_wb;
  logic        e_wben, e_err;
  logic [2:0]  e_mode;
  logic        m_valid = 1'b0;
  logic        stalled = 1'b0;
  logic [31:0] p_addr, p_wb;
  logic        p_wben, p_err;

  always #2.5 clk = ~clk;

  ldst_addr_gen u_ldst_addr_gen (.*);

  function automatic logic [31:0] sx(input logic [11:0] o);
    return 32'($signed(o));
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] m, input logic [31:0] f, b, ix, pc,
                       input logic [11:0] o, input logic [1:0] sc, sz,
                       input logic dc, pr);
    logic [31:0] st, nb;
    st = 32'd1 << sz;
    nb = dc ? b - st : b + st;
    e_mode = m; e_wben = 1'b0; e_wb = '0; e_err = 1'b0; e_addr = '0;
    case (m)
      3'd0: e_addr = f;
      3'd1: e_addr = b;
      3'd2: e_addr = b + sx(o);
      3'd3: e_addr = b + ix;
      3'd4: e_addr = b + ix * (32'd1 << sc) + sx(o);
      3'd5: e_addr = pc + sx(o);
      3'd6: begin e_addr = pr ? nb : b; e_wben = 1'b1; e_wb = nb; end
      default: e_err = 1'b1;
    endcase
  endtask

  task automatic cyc(input logic v, input logic [2:0] m, input logic [31:0] f, b, ix, pc,
                     input logic [11:0] o, input logic [1:0] sc, sz,
                     input logic dc, pr, input logic ordy);
    logic acc;
    @(negedge clk);
    chk("R9", "out_valid", 32'(out_valid), 32'(m_valid));
    if (stalled) begin
      chk("R10", "held addr", out_addr, p_addr);
      chk("R10", "held wb", {out_wb_data[30:0], out_wb_en}, {p_wb[30:0], p_wben});
      chk("R10", "held err", 32'(out_err), 32'(p_err));
    end
    if (out_valid) begin
      chk(tag(e_mode), "addr", out_addr, e_addr);
      chk(e_mode == 3'd6 ? "R7" : "R8", "wb_en", 32'(out_wb_en), 32'(e_wben));
      chk(e_mode == 3'd6 ? "R7" : "R8", "wb_data", out_wb_data, e_wb);
      chk("R8", "err", 32'(out_err), 32'(e_err));
    end else begin
      chk("R11", "idle outputs", out_addr | out_wb_data | 32'({out_wb_en, out_err}), 32'd0);
    end
    p_addr = out_addr; p_wb = out_wb_data; p_wben = out_wb_en; p_err = out_err;
    out_ready = ordy;
    in_valid = v; in_mode = m; in_field = f; in_base = b; in_index = ix; in_pc = pc;
    in_offset = o; in_scale = sc; in_size = sz; in_dec = dc; in_pre = pr;
    #1;
    chk("R9", "in_ready", 32'(in_ready), 32'(!m_valid || ordy));
    acc = v && (!m_valid || ordy);
    stalled = m_valid && !ordy;
    if (acc) model(m, f, b, ix, pc, o, sc, sz, dc, pr);
    m_valid = acc ? 1'b1 : (ordy ? 1'b0 : m_valid);
  endtask

  task automatic go(input logic [2:0] m, input logic [31:0] f, b, ix, pc,
                    input logic [11:0] o, input logic [1:0] sc, sz, input logic dc, pr);
    cyc(1'b1, m, f, b, ix, pc, o, sc, sz, dc, pr, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R11", "reset valid", 32'(out_valid), 32'd0);
    chk("R11", "reset flags", 32'({out_wb_en, out_err}), 32'd0);
    chk("R11", "reset addr", out_addr | out_wb_data, 32'd0);
    // directed corners
    go(3'd0, 32'hDEAD_BEEF, 32'h1, 32'h2, 32'h3, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0);      // R1
    go(3'd1, 32'h0, 32'hCAFE_0000, 32'h2, 32'h3, 12'h5, 2'd0, 2'd0, 1'b0, 1'b0);       // R2
    go(3'd2, 32'h0, 32'h0000_0100, 32'h0, 32'h0, 12'h800, 2'd0, 2'd0, 1'b0, 1'b0);     // R3 negative
    go(3'd2, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 12'h7FF, 2'd0, 2'd0, 1'b0, 1'b0);     // R3 wrap
    go(3'd3, 32'h0, 32'hFFFF_FFF0, 32'h20, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0);      // R4 wrap
    for (int s = 0; s < 4; s++)
      go(3'd4, 32'h0, 32'h1000, 32'h8000_0003, 32'h0, 12'hFFC, 2'(s), 2'd0, 1'b0, 1'b0); // R5
    go(3'd5, 32'h0, 32'h0, 32'h0, 32'h0000_0004, 12'h800, 2'd0, 2'd0, 1'b0, 1'b0);      // R6
    for (int k = 0; k < 4; k++)
      go(3'd6, 32'h0, 32'h0, 32'h0, 32'h0, 12'h0, 2'd3, 2'(k), k[0], k[1]);          // R7 from zero
    go(3'd7, 32'h1, 32'h2, 32'h3, 32'h4, 12'h5, 2'd1, 2'd1, 1'b1, 1'b1);               // R8
    // stall then release
    go(3'd6, 32'h0, 32'h100, 32'h0, 32'h0, 12'h0, 2'd0, 2'd2, 1'b1, 1'b1);
    cyc(1'b1, 3'd0, 32'h5555_5555, 32'h0, 32'h0, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0); // R10
    cyc(1'b1, 3'd0, 32'h5555_5555, 32'h0, 32'h0, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0); // R10
    cyc(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rb;
      rb = ($urandom % 4 == 0) ? (32'hFFFF_FFF8 + ($urandom % 16)) : $urandom;
      cyc(($urandom % 4) != 0, 3'($urandom), $urandom, rb, $urandom, $urandom,
          12'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
          ($urandom % 3) != 0);
    end
    cyc(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0, 12'h0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule